// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block sits next to a small processor core and decides when the core and its surrounding clock domains may go quiet. Software programs a byte-wide control register over a simple register bus. The register holds a low-power mode code and an arm bit. The core reports each executed sleep instruction as a one-cycle strobe. When the arm bit is set and the mode code is one the block supports, the strobe puts the controller to sleep. The controller then lowers the clock-enable outputs for the domains that the chosen mode switches off, and it holds the core halted.

An enabled interrupt reported by the interrupt controller wakes the block. In the mode that stops the main oscillator, the block first waits a parameterised start-up time with the oscillator re-enabled. In every mode it then keeps the core halted for four more cycles with all clocks running. Finally it releases the core and pulses a one-cycle resume indication, so the core services the interrupt and continues after the sleep instruction. A reset during sleep returns everything to the running state with no resume pulse, so the core starts again from its reset vector. A status output exposes the controller state.

Top module: `sleepPowerCtl`

## Requirements
- R1: The control register reads back as {4'b0000, mode[2:0], arm}. Mode occupies bits 3..1 and arm occupies bit 0. Bits 7..4 always read 0, and writing them has no effect.
- R2: After reset the register reads 0, the status is RUN (2'd0), every clock enable is 1, coreHalt is 0 and resumeIrq is 0.
- R3: A sleep strobe while the arm bit is 0 leaves the status at RUN.
- R4: A sleep strobe while RUN, with arm 1 and a supported mode, sets the status to SLEEP (2'd1) from the next cycle. coreHalt is 1 in every state other than RUN.
- R5: The mode codes 3'b011, 3'b100, 3'b101 and 3'b111 are reserved. A strobe with any of them leaves the status at RUN.
- R6: The clock enables in SLEEP follow the mode captured at entry. Idle (3'b000) lowers only cpuClkEn. Noise-reduction (3'b001) lowers cpuClkEn and ioClkEn. Deep (3'b010) lowers all five enables, oscEn included. Standby (3'b110) lowers all of them except oscEn.
- R7: Waking from Deep enters STARTUP (2'd2) for STARTUP_CYCLES cycles. During STARTUP only oscEn is raised.
- R8: Waking from Idle, Noise-reduction or Standby goes directly from SLEEP to HALT (2'd3).
- R9: HALT lasts exactly 4 cycles with all clock enables at 1. The controller then returns to RUN, and resumeIrq is 1 for that first RUN cycle only.
- R10: A reset during SLEEP returns to RUN with the register cleared and no resumeIrq pulse.
- R11: Waking does not clear the arm bit.
- R12: wakeIrq outside SLEEP has no effect, and a sleep strobe outside RUN has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| sleepStrobe | input | 1 | Sleep instruction executed, one cycle |
| wakeIrq | input | 1 | Enabled interrupt pending |
| cpuClkEn | output | 1 | CPU clock enable |
| ioClkEn | output | 1 | I/O clock enable |
| adcClkEn | output | 1 | Converter clock enable |
| asyncClkEn | output | 1 | Asynchronous timer clock enable |
| oscEn | output | 1 | Main oscillator enable |
| coreHalt | output | 1 | Core held halted |
| resumeIrq | output | 1 | One-cycle pulse: core resumes into interrupt service |
| pwrState | output | 2 | Status: 0 RUN, 1 SLEEP, 2 STARTUP, 3 HALT |

## Verification
Some rules are checked on every cycle. These are the entry rules for a strobe (arm clear, reserved code, accepted request), the link between halt and status, the all-clocks-on condition in HALT and the oscillator-only condition in STARTUP, the rule that SLEEP persists with no interrupt, and the tie between the resume pulse and the HALT-to-RUN step. Other behaviour only shows up in the bench's scenarios, which follow a reference model: the exact length of the start-up and halt windows, the per-mode enable sets, a reset during sleep, and the arm bit surviving a wake-up.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_STARTUP = 2'd2,
    ST_HALT    = 2'd3
  } pwrState_t;

  localparam logic [2:0] MODE_IDLE    = 3'b000;
  localparam logic [2:0] MODE_NOISE   = 3'b001;
  localparam logic [2:0] MODE_DEEP    = 3'b010;
  localparam logic [2:0] MODE_STANDBY = 3'b110;

  // strobes from control to datapath
  typedef struct packed {
    logic captureMode;
    logic loadStartup;
    logic loadHalt;
    logic countDown;
  } ctrlStrobe_t;

  function automatic logic isSupportedMode(input logic [2:0] m);
    return (m == MODE_IDLE) || (m == MODE_NOISE) ||
           (m == MODE_DEEP) || (m == MODE_STANDBY);
  endfunction

endpackage

// File: rtl/sleep_dp.sv
module sleep_dp
  import sleep_pkg::*;
#(
  parameter int STARTUP_CYCLES = 16,
  parameter int HALT_CYCLES    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  ctrlStrobe_t strobe,
  input  pwrState_t   curState,
  output logic        armBit,
  output logic        reqSupported,
  output logic        modeIsDeep,
  output logic        cntZero,
  output logic [4:0]  clkEnables
);
  localparam int MAX_CNT = (STARTUP_CYCLES > HALT_CYCLES) ? STARTUP_CYCLES : HALT_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] STARTUP_LOAD = CNT_W'((STARTUP_CYCLES > 0) ? STARTUP_CYCLES - 1 : 0);
  localparam logic [CNT_W-1:0] HALT_LOAD    = CNT_W'((HALT_CYCLES > 0) ? HALT_CYCLES - 1 : 0);
  localparam logic [7:0] WR_MASK = 8'h0F;

  logic [7:0]       ctrlQ;
  logic [2:0]       modeQ;
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else if (regWrEn) ctrlQ <= regWrData & WR_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_IDLE;
    else if (strobe.captureMode) modeQ <= ctrlQ[3:1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntQ <= '0;
    else if (strobe.loadStartup) cntQ <= STARTUP_LOAD;
    else if (strobe.loadHalt) cntQ <= HALT_LOAD;
    else if (strobe.countDown && cntQ != '0) cntQ <= cntQ - 1'b1;
  end

  assign regRdData    = ctrlQ;
  assign armBit       = ctrlQ[0];
  assign reqSupported = isSupportedMode(ctrlQ[3:1]);
  assign modeIsDeep   = (modeQ == MODE_DEEP);
  assign cntZero      = (cntQ == '0);

  // clkEnables = {cpu, io, adc, async, osc}
  always_comb begin
    unique case (curState)
      ST_SLEEP: begin
        unique case (modeQ)
          MODE_IDLE:    clkEnables = 5'b01111;
          MODE_NOISE:   clkEnables = 5'b00111;
          MODE_STANDBY: clkEnables = 5'b00001;
          default:      clkEnables = 5'b00000;
        endcase
      end
      ST_STARTUP: clkEnables = 5'b00001;
      default:    clkEnables = 5'b11111;
    endcase
  end

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int STARTUP_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepStrobe,
  input  logic        wakeIrq,
  input  logic        armBit,
  input  logic        reqSupported,
  input  logic        modeIsDeep,
  input  logic        cntZero,
  output ctrlStrobe_t strobe,
  output pwrState_t   curState,
  output logic        resumeIrq
);
  localparam bit USE_STARTUP = (STARTUP_CYCLES > 0);

  pwrState_t stateQ, stateD;
  logic      resumeD;

  always_comb begin
    stateD  = stateQ;
    strobe  = '0;
    resumeD = 1'b0;
    unique case (stateQ)
      ST_RUN: begin
        if (sleepStrobe && armBit && reqSupported) begin
          strobe.captureMode = 1'b1;
          stateD = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (wakeIrq) begin
          if (modeIsDeep && USE_STARTUP) begin
            strobe.loadStartup = 1'b1;
            stateD = ST_STARTUP;
          end else begin
            strobe.loadHalt = 1'b1;
            stateD = ST_HALT;
          end
        end
      end
      ST_STARTUP: begin
        strobe.countDown = 1'b1;
        if (cntZero) begin
          strobe.loadHalt = 1'b1;
          stateD = ST_HALT;
        end
      end
      ST_HALT: begin
        strobe.countDown = 1'b1;
        if (cntZero) begin
          stateD  = ST_RUN;
          resumeD = 1'b1;
        end
      end
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_RUN;
      resumeIrq <= 1'b0;
    end else begin
      stateQ    <= stateD;
      resumeIrq <= resumeD;
    end
  end

  assign curState = stateQ;

endmodule

// File: rtl/sleepPowerCtl.sv
module sleepPowerCtl
  import sleep_pkg::*;
#(
  parameter int STARTUP_CYCLES = 16,
  parameter int HALT_CYCLES    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       sleepStrobe,
  input  logic       wakeIrq,
  output logic       cpuClkEn,
  output logic       ioClkEn,
  output logic       adcClkEn,
  output logic       asyncClkEn,
  output logic       oscEn,
  output logic       coreHalt,
  output logic       resumeIrq,
  output logic [1:0] pwrState
);
  ctrlStrobe_t strobe;
  pwrState_t   curState;
  logic        armBit, reqSupported, modeIsDeep, cntZero;
  logic [4:0]  clkEnables;

  sleep_ctrl #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sleepStrobe(sleepStrobe), .wakeIrq(wakeIrq),
    .armBit(armBit), .reqSupported(reqSupported), .modeIsDeep(modeIsDeep),
    .cntZero(cntZero), .strobe(strobe), .curState(curState), .resumeIrq(resumeIrq)
  );

  sleep_dp #(.STARTUP_CYCLES(STARTUP_CYCLES), .HALT_CYCLES(HALT_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .strobe(strobe), .curState(curState),
    .armBit(armBit), .reqSupported(reqSupported), .modeIsDeep(modeIsDeep),
    .cntZero(cntZero), .clkEnables(clkEnables)
  );

  assign {cpuClkEn, ioClkEn, adcClkEn, asyncClkEn, oscEn} = clkEnables;
  assign coreHalt = (curState != ST_RUN);
  assign pwrState = curState;

endmodule

// File: rtl/sleepPowerCtl_chk.sv
module sleepPowerCtl_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] regRdData,
  input logic       sleepStrobe,
  input logic       wakeIrq,
  input logic       cpuClkEn,
  input logic       ioClkEn,
  input logic       adcClkEn,
  input logic       asyncClkEn,
  input logic       oscEn,
  input logic       coreHalt,
  input logic       resumeIrq,
  input logic [1:0] pwrState
);
  logic reservedReq;
  assign reservedReq = (regRdData[3:1] == 3'b011) || (regRdData[3:1] == 3'b100) ||
                       (regRdData[3:1] == 3'b101) || (regRdData[3:1] == 3'b111);

  p_unarmed_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd0 && sleepStrobe && !regRdData[0]) |=> pwrState == 2'd0);

  p_reserved_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd0 && sleepStrobe && reservedReq) |=> pwrState == 2'd0);

  p_enter_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd0 && sleepStrobe && regRdData[0] && !reservedReq) |=> pwrState == 2'd1);

  p_halt_state_r4: assert property (@(posedge clk) disable iff (!rstN)
    coreHalt == (pwrState != 2'd0));

  p_halt_clocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 2'd3 |-> (cpuClkEn && ioClkEn && adcClkEn && asyncClkEn && oscEn));

  p_startup_osc_r7: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 2'd2 |-> (oscEn && !cpuClkEn && !ioClkEn && !adcClkEn && !asyncClkEn));

  p_sleep_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd1 && !wakeIrq) |=> pwrState == 2'd1);

  p_sleep_cpu_r6: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 2'd1 |-> !cpuClkEn);

  p_resume_r9: assert property (@(posedge clk) disable iff (!rstN)
    resumeIrq |-> (pwrState == 2'd0 && $past(pwrState) == 2'd3));

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[7:4] == 4'b0000);

endmodule

bind sleepPowerCtl sleepPowerCtl_chk u_chk (
  .clk(clk), .rstN(rstN), .regRdData(regRdData), .sleepStrobe(sleepStrobe),
  .wakeIrq(wakeIrq), .cpuClkEn(cpuClkEn), .ioClkEn(ioClkEn), .adcClkEn(adcClkEn),
  .asyncClkEn(asyncClkEn), .oscEn(oscEn), .coreHalt(coreHalt),
  .resumeIrq(resumeIrq), .pwrState(pwrState)
);

// File: tb/sleepPowerCtl_tb.sv
module sleepPowerCtl_tb;
  localparam int SU = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic sleepStrobe = 1'b0;
  logic wakeIrq = 1'b0;
  logic [7:0] regRdData;
  logic cpuClkEn, ioClkEn, adcClkEn, asyncClkEn, oscEn, coreHalt, resumeIrq;
  logic [1:0] pwrState;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  sleepPowerCtl #(.STARTUP_CYCLES(SU), .HALT_CYCLES(4)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .sleepStrobe(sleepStrobe), .wakeIrq(wakeIrq),
    .cpuClkEn(cpuClkEn), .ioClkEn(ioClkEn), .adcClkEn(adcClkEn),
    .asyncClkEn(asyncClkEn), .oscEn(oscEn), .coreHalt(coreHalt),
    .resumeIrq(resumeIrq), .pwrState(pwrState)
  );

  // behavioural reference model
  int mState, mCnt, mMode, mReg;
  bit mResume;

  function automatic bit supported(int m);
    return m == 0 || m == 1 || m == 2 || m == 6;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mMode = 0; mReg = 0; mResume = 0;
    end else begin
      mResume = 0;
      case (mState)
        0: if (sleepStrobe && mReg[0] && supported((mReg >> 1) & 7)) begin
             mMode = (mReg >> 1) & 7; mState = 1;
           end
        1: if (wakeIrq) begin
             if (mMode == 2) begin mState = 2; mCnt = SU; end
             else begin mState = 3; mCnt = 4; end
           end
        2: begin mCnt--; if (mCnt == 0) begin mState = 3; mCnt = 4; end end
        default: begin mCnt--; if (mCnt == 0) begin mState = 0; mResume = 1; end end
      endcase
      if (regWrEn) mReg = regWrData & 8'h0F;
    end
  end

  function automatic logic [4:0] expEn();
    if (mState == 2) return 5'b00001;
    if (mState != 1) return 5'b11111;
    case (mMode)
      0: return 5'b01111;
      1: return 5'b00111;
      6: return 5'b00001;
      default: return 5'b00000;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // compare every cycle, before inputs change
  always @(negedge clk) begin
    cycles++;
    if (rstN && !done) begin
      check("R1 regRdData", regRdData, mReg);
      check("R4 pwrState", pwrState, mState);
      check("R6 clock enables", {cpuClkEn, ioClkEn, adcClkEn, asyncClkEn, oscEn}, expEn());
      check("R4 coreHalt", coreHalt, mState != 0);
      check("R9 resumeIrq", resumeIrq, mResume);
    end
    if (cycles > 100000 && !done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  task automatic drive(input logic st, input logic wk, input logic wr, input logic [7:0] d);
    @(negedge clk); #1;
    sleepStrobe = st; wakeIrq = wk; regWrEn = wr; regWrData = d;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic goSleep(input logic [2:0] m);
    drive(1'b0, 1'b0, 1'b1, {4'b0, m, 1'b1});
    drive(1'b1, 1'b0, 1'b0, 8'h00);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    idle();
    // R2 reset state
    check("R2 status", pwrState, 0);
    check("R2 register", regRdData, 0);
    check("R2 enables", {cpuClkEn, ioClkEn, adcClkEn, asyncClkEn, oscEn}, 5'b11111);
    check("R2 resume", resumeIrq, 0);

    // R1 upper bits dropped
    drive(1'b0, 1'b0, 1'b1, 8'hFA);
    idle();
    check("R1 readback", regRdData, 8'h0A);

    // R3 strobe unarmed (Deep code, arm 0)
    drive(1'b0, 1'b0, 1'b1, 8'h04);
    drive(1'b1, 1'b0, 1'b0, 8'h00);
    idle();
    check("R3 unarmed strobe", pwrState, 0);

    // R5 reserved codes
    for (int k = 0; k < 4; k++) begin
      logic [2:0] rc;
      rc = (k == 0) ? 3'b011 : (k == 1) ? 3'b100 : (k == 2) ? 3'b101 : 3'b111;
      goSleep(rc);
      check("R5 reserved ignored", pwrState, 0);
    end

    // R12 wake while running
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    idle();
    check("R12 wake in RUN", pwrState, 0);

    // Idle sleep, R6, R8, R9, R11
    goSleep(3'b000);
    check("R4 entered sleep", pwrState, 1);
    check("R6 idle cpu off", cpuClkEn, 0);
    check("R6 idle io on", ioClkEn, 1);
    drive(1'b1, 1'b0, 1'b0, 8'h00);
    idle();
    check("R12 strobe in SLEEP", pwrState, 1);
    repeat (3) idle();
    check("R12 sleep holds", pwrState, 1);
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    idle();
    check("R8 idle skips startup", pwrState, 3);
    repeat (3) idle();
    check("R9 still halted", pwrState, 3);
    idle();
    check("R9 back to run", pwrState, 0);
    check("R9 resume pulse", resumeIrq, 1);
    idle();
    check("R9 resume one cycle", resumeIrq, 0);
    check("R11 arm kept", regRdData[0], 1);

    // Noise reduction
    goSleep(3'b001);
    check("R6 noise io off", ioClkEn, 0);
    check("R6 noise adc on", adcClkEn, 1);
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    idle();
    check("R8 noise skips startup", pwrState, 3);
    repeat (6) idle();

    // Deep with start-up
    goSleep(3'b010);
    check("R6 deep osc off", oscEn, 0);
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    idle();
    check("R7 startup entered", pwrState, 2);
    check("R7 osc on", oscEn, 1);
    repeat (SU - 1) idle();
    check("R7 startup length", pwrState, 2);
    idle();
    check("R7 startup ends", pwrState, 3);
    repeat (4) idle();
    check("R9 deep resume", resumeIrq, 1);

    // Standby
    goSleep(3'b110);
    check("R6 standby osc on", oscEn, 1);
    check("R6 standby async off", asyncClkEn, 0);
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    idle();
    check("R8 standby skips startup", pwrState, 3);
    repeat (6) idle();

    // R10 reset while asleep
    goSleep(3'b010);
    @(negedge clk); #1 rstN = 1'b0;
    repeat (2) @(negedge clk);
    #1 rstN = 1'b1;
    idle();
    check("R10 status after reset", pwrState, 0);
    check("R10 register cleared", regRdData, 0);
    check("R10 no resume", resumeIrq, 0);
    repeat (3) idle();
    check("R10 no late resume", resumeIrq, 0);

    finish_run();
  end

endmodule